// File: doc/BRIEF.md
# Quadrature Up/Down Position Counter

This block keeps a wrapping position count from two digital inputs, A and B. It can be configured at run time to read the inputs in one of two ways. In quadrature mode the block compares each A/B sample with the one before it, so every legal transition of an incremental encoder moves the count by one. In step/direction mode each rising edge of A is a step, and the level of B sets its sign.

A sample-period input selects how the count reaches the result output. With a period of zero, the result follows the running position with no extra delay, which gives an absolute position. With a non-zero period, a free-running timebase splits time into windows of that many clock cycles. At the end of each window the result takes the count gathered in that window, a one-cycle flag pulses, and the counter starts again. That turns the same counter into a velocity meter. A count that lands on the closing cycle of a window is carried into the next window, so no counts are lost.

The inputs are expected to be synchronous to `clk` and already free of glitches.

Top module: `qdc_position_counter`

## Requirements
- R1: While `rst_n` is low, `pos_z` reads 0 and `sample_flag` reads 0. After reset the previous-sample state is A=0, B=0.
- R2: With `mode_quad`=0, a sample where A is 1 and the previous A was 0 changes the count by +1 if B is 1 and by -1 if B is 0. Any other change of A or B alone does not change the count.
- R3: With `mode_quad`=1, the state code {A,B} advances around the cycle 00, 01, 11, 10, 00. A move one step forward adds 1 and a move one step backward subtracts 1.
- R4: With `mode_quad`=1, a sample where A and B both differ from the previous sample leaves the count unchanged. That sample becomes the new reference state.
- R5: With `period_x`=0, `pos_z` equals the running count one clock edge after the sample that changed it, and `sample_flag` stays 0.
- R6: With `period_x`=N>0, `sample_flag` is high for one cycle out of every N. `pos_z` then holds the net count of the N samples taken in that window and keeps it until the next capture.
- R7: A count whose sample falls on the closing edge of a window is not lost. It becomes the first count of the next window, so the counter reloads to -1, 0 or +1.
- R8: The count wraps modulo 2^W. One down step from 0 reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| mode_quad | input | 1 | 1 = quadrature decode, 0 = step/direction |
| period_x | input | W | Window length in clock cycles; 0 = continuous position |
| in_a | input | 1 | Input A (encoder phase A or step) |
| in_b | input | 1 | Input B (encoder phase B or direction) |
| pos_z | output | W | Result: absolute position or count per window |
| sample_flag | output | 1 | One-cycle pulse when a window result is captured |

## Verification
The case that needs the most care is when the end of a window and an input count happen on the same clock edge. In that cycle the capture must take the old count, and the reload must keep the new one. The bench provokes this by running the quadrature inputs forward on every cycle with a three-cycle window, so every window-closing edge carries a count. Each captured value must then be exactly 3. A reference model running alongside the design computes every window total, and a scoreboard compares each captured result with that model. The model also covers step patterns, including a one-cycle window where capture and counting coincide on every edge.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef enum logic {
    MODE_STEP = 1'b0,
    MODE_QUAD = 1'b1
  } qdc_mode_e;

  // position of an {a,b} code on the cycle 00 -> 01 -> 11 -> 10
  function automatic logic [1:0] ring_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   ring_pos = 2'd0;
      2'b01:   ring_pos = 2'd1;
      2'b11:   ring_pos = 2'd2;
      default: ring_pos = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qdc_decoder.sv
module qdc_decoder
  import qdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  qdc_mode_e mode,
  input  logic      in_a,
  input  logic      in_b,
  output logic      cnt_en,
  output logic      cnt_up
);

  logic prev_a, prev_b;
  logic [1:0] step_dist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= in_a;
      prev_b <= in_b;
    end
  end

  always_comb begin
    step_dist = ring_pos(in_a, in_b) - ring_pos(prev_a, prev_b);
    cnt_en    = 1'b0;
    cnt_up    = 1'b0;
    if (mode == MODE_QUAD) begin
      // distance 1 = forward, 3 = backward, 0 or 2 = no count
      cnt_en = step_dist[0];
      cnt_up = ~step_dist[1];
    end else begin
      cnt_en = in_a & ~prev_a;
      cnt_up = in_b;
    end
  end

endmodule

// File: rtl/qdc_timebase.sv
module qdc_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_x,
  output logic         capture
);

  logic [W-1:0] tick_q, tick_d;
  logic         active;

  assign active  = (period_x != '0);
  assign capture = active && (tick_q >= period_x - W'(1));

  always_comb begin
    if (!active || capture) tick_d = '0;
    else                    tick_d = tick_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

endmodule

// File: rtl/qdc_accum.sv
module qdc_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_up,
  input  logic         track,
  input  logic         capture,
  output logic [W-1:0] result,
  output logic         flag
);

  logic [W-1:0] pos_q, pos_d, delta, res_d;
  logic         res_en;

  assign delta = !cnt_en ? '0 : (cnt_up ? W'(1) : '1);

  always_comb begin
    // a count on the capture edge opens the next window
    pos_d  = capture ? delta : pos_q + delta;
    res_en = track | capture;
    res_d  = track ? pos_d : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      result <= '0;
      flag   <= 1'b0;
    end else begin
      pos_q <= pos_d;
      flag  <= capture;
      if (res_en) result <= res_d;
    end
  end

endmodule

// File: rtl/qdc_position_counter.sv
module qdc_position_counter
  import qdc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_quad,
  input  logic [W-1:0] period_x,
  input  logic         in_a,
  input  logic         in_b,
  output logic [W-1:0] pos_z,
  output logic         sample_flag
);

  qdc_mode_e mode;
  logic      cnt_en, cnt_up, capture, track;

  assign mode  = mode_quad ? MODE_QUAD : MODE_STEP;
  assign track = (period_x == '0);

  qdc_decoder u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .in_a   (in_a),
    .in_b   (in_b),
    .cnt_en (cnt_en),
    .cnt_up (cnt_up)
  );

  qdc_timebase #(.W(W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_x (period_x),
    .capture  (capture)
  );

  qdc_accum #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_up  (cnt_up),
    .track   (track),
    .capture (capture),
    .result  (pos_z),
    .flag    (sample_flag)
  );

endmodule

// File: rtl/qdc_checker.sv
module qdc_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_quad,
  input logic [W-1:0] period_x,
  input logic         in_a,
  input logic         in_b,
  input logic [W-1:0] pos_z,
  input logic         sample_flag
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (pos_z == '0 && !sample_flag);
    end
  end

  assert_step_only_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !mode_quad && period_x == '0 && !(in_a && !$past(in_a)))
    |=> $stable(pos_z));

  assert_quad_single_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mode_quad && period_x == '0 &&
     ((in_a != $past(in_a)) ^ (in_b != $past(in_b))))
    |=> !$stable(pos_z));

  assert_quad_double_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mode_quad && period_x == '0 &&
     in_a != $past(in_a) && in_b != $past(in_b))
    |=> $stable(pos_z));

  assert_no_flag_tracking_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_x == '0) |=> !sample_flag);

  assert_flag_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_flag && period_x > W'(1)) |=> !sample_flag);

endmodule

bind qdc_position_counter qdc_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_quad   (mode_quad),
  .period_x    (period_x),
  .in_a        (in_a),
  .in_b        (in_b),
  .pos_z       (pos_z),
  .sample_flag (sample_flag)
);

// File: tb/qdc_position_counter_test.sv
module qdc_position_counter_test;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         mode_quad = 1'b0;
  logic [W-1:0] period_x = '0;
  logic         in_a = 1'b0, in_b = 1'b0;
  wire  [W-1:0] pos_z;
  wire          sample_flag;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  int qi = 0;

  qdc_position_counter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_quad(mode_quad), .period_x(period_x),
    .in_a(in_a), .in_b(in_b), .pos_z(pos_z), .sample_flag(sample_flag)
  );

  function automatic int ring(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // reference model: runs just after each edge on the inputs that edge sampled
  logic         ma = 1'b0, mb = 1'b0;
  logic [W-1:0] mpos = '0, mtb = '0;
  always @(posedge clk) begin
    int d;
    int k;
    #1;
    d = 0;
    if (!rst_n) begin
      ma = 0; mb = 0; mpos = '0; mtb = '0;
    end else begin
      if (mode_quad) begin
        k = (ring(in_a, in_b) - ring(ma, mb) + 4) % 4;
        if (k == 1) d = 1;
        else if (k == 3) d = -1;
      end else if (in_a && !ma) begin
        d = in_b ? 1 : -1;
      end
      if (period_x == '0) begin
        mpos = mpos + W'(d);
      end else if (mtb >= period_x - W'(1)) begin
        exp_q.push_back(mpos);
        mpos = W'(d);
        mtb = '0;
      end else begin
        mpos = mpos + W'(d);
        mtb = mtb + W'(1);
      end
      ma = in_a; mb = in_b;
    end
  end

  // monitor: each flag pulse pops one expected window total
  always @(negedge clk) begin
    logic [W-1:0] e;
    if (rst_n && sample_flag && !done) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5 R6 unexpected flag act=%h exp=no capture", pos_z);
      end else begin
        e = exp_q.pop_front();
        if (pos_z !== e) begin
          bad++;
          $display("FAIL R6 R7 window total act=%h exp=%h", pos_z, e);
        end
      end
    end
  end

  task automatic check_z(input logic [W-1:0] e, input string tag);
    total++;
    if (pos_z !== e) begin
      bad++;
      $display("FAIL %s pos_z act=%h exp=%h", tag, pos_z, e);
    end
  endtask

  task automatic check_flag(input logic e, input string tag);
    total++;
    if (sample_flag !== e) begin
      bad++;
      $display("FAIL %s sample_flag act=%b exp=%b", tag, sample_flag, e);
    end
  endtask

  task automatic start(input logic q, input logic [W-1:0] x);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R6 missing captures act=%0d exp=0", exp_q.size());
    end
    exp_q.delete();
    in_a = 0; in_b = 0; mode_quad = q; period_x = x; qi = 0;
    repeat (2) @(negedge clk);
    check_z('0, "R1");
    check_flag(1'b0, "R1");
    rst_n = 1'b1;
  endtask

  task automatic step_pulse(input logic dir);
    @(negedge clk);
    in_b = dir; in_a = 1'b1;
    @(negedge clk);
    in_a = 1'b0;
  endtask

  task automatic quad_move(input int k);
    @(negedge clk);
    qi = (qi + k + 4) % 4;
    case (qi)
      0: {in_a, in_b} = 2'b00;
      1: {in_a, in_b} = 2'b01;
      2: {in_a, in_b} = 2'b11;
      default: {in_a, in_b} = 2'b10;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // step/direction, continuous position
    start(1'b0, '0);
    repeat (3) step_pulse(1'b1);
    @(negedge clk); check_z(W'(3), "R2 up steps");
    repeat (2) step_pulse(1'b0);
    @(negedge clk); check_z(W'(1), "R2 down steps");
    @(negedge clk) in_b = 1'b1;
    @(negedge clk) in_b = 1'b0;
    @(negedge clk) in_b = 1'b1;
    @(negedge clk); check_z(W'(1), "R2 B alone ignored");
    @(negedge clk) in_a = 1'b1;
    @(negedge clk); check_z(W'(2), "R2 rise with B high");
    @(negedge clk) in_b = 1'b0;
    @(negedge clk) in_b = 1'b1;
    @(negedge clk); check_z(W'(2), "R2 A held high");
    @(negedge clk) in_a = 1'b0;
    @(negedge clk); check_z(W'(2), "R2 A fall ignored");
    repeat (3) step_pulse(1'b0);
    @(negedge clk); check_z('1, "R8 wrap below zero");
    check_flag(1'b0, "R5 no flag when tracking");

    // quadrature, continuous position
    start(1'b1, '0);
    repeat (8) quad_move(1);
    @(negedge clk); check_z(W'(8), "R3 forward");
    repeat (3) quad_move(-1);
    @(negedge clk); check_z(W'(5), "R3 backward");
    quad_move(2);
    @(negedge clk); check_z(W'(5), "R4 double jump");
    quad_move(2);
    @(negedge clk); check_z(W'(5), "R4 double jump back");
    quad_move(1);
    @(negedge clk); check_z(W'(6), "R3 after jump");
    check_flag(1'b0, "R5 no flag when tracking");

    // quadrature, 3-cycle windows, a count on every edge
    start(1'b1, W'(3));
    for (int i = 0; i < 30; i++) begin
      quad_move(1);
      if (i > 6 && sample_flag) check_z(W'(3), "R7 count on capture edge kept");
    end
    repeat (6) @(negedge clk);

    // step/direction, 5-cycle windows, mixed directions
    start(1'b0, W'(5));
    for (int i = 0; i < 12; i++) step_pulse(i % 3 != 0);
    repeat (8) @(negedge clk);

    // one-cycle window: capture on every edge
    start(1'b0, W'(1));
    for (int i = 0; i < 6; i++) step_pulse(i % 2 == 0);
    repeat (4) @(negedge clk);

    // quadrature, long window with reversals
    start(1'b1, W'(7));
    for (int i = 0; i < 20; i++) quad_move((i % 5 == 4) ? -1 : 1);
    repeat (10) @(negedge clk);

    start(1'b0, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule